// File: doc/BRIEF.md
# Endpoint Handshake Control

This block is the control state for one endpoint of a USB function controller. A CPU writes an 8-bit control byte and reads back an 8-bit status byte. The protocol engine sends a one-cycle strobe for each IN or OUT token, and later a completion strobe that reports either normal success or failure. For each token the block compares the FIFO byte count (IN) or free space (OUT) with the endpoint's max packet size. It then picks a handshake (data/ACK, NAK or STALL) and reports it one clock later, together with the byte count to send and the data toggle to use.

When a transaction it accepted finishes normally, the block updates its own bits. It flips the data toggle. It can raise force-NAK after any completion, or only after a short OUT packet. It clears its short-packet enable once a short IN packet has gone out. The handshake is decided from the control bits as they stood on the token cycle, so writes made while a transaction runs take effect only from the next token.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: After reset every control bit, the toggle and `hs_valid` are 0 and `cpu_rdata` reads 0x00. The read byte is laid out as bit7 auto-NAK, bit6 short enable, bit5 short-NAK disable, bit4 toggle, bits3:2 always 0, bit1 force NAK, bit0 force STALL.
- R2: Writing 1 in bit3 sets the toggle and writing 1 in bit2 clears it. If both are 1 in the same write, the toggle is cleared. Writing 0 in both leaves the toggle unchanged.
- R3: With force STALL set, the next token gets `hs_code` 2'b10 (STALL), whatever the force NAK bit and the FIFO levels are.
- R4: With force NAK set and force STALL clear, a token gets `hs_code` 2'b01 (NAK), whatever the FIFO levels are.
- R5: With no force bit set, an IN token gets NAK when `fifo_count` < `max_pkt` and short enable is 0. Otherwise it gets 2'b00 (data) with `tx_len` = min(`fifo_count`, `max_pkt`), which is 0 for an empty FIFO. `tx_len` is 0 on any non-data answer.
- R6: With no force bit set, an OUT token gets NAK when `fifo_free` < `max_pkt` and 2'b00 (ACK) otherwise.
- R7: The toggle flips only on `done_ok` for a transaction answered 2'b00. It is unchanged by NAK or STALL answers, by `done_err` and by a stray `done_ok`. `hs_toggle` gives the toggle as it was at the token.
- R8: With auto-NAK set, a normal completion sets force NAK.
- R9: A normal OUT completion with `rx_count` < `max_pkt` sets force NAK when bit5 is 0, and leaves force NAK clear when bit5 is 1.
- R10: Short enable clears itself after a normal completion of an IN transaction that sent fewer than `max_pkt` bytes. It stays set after a full-size packet.
- R11: A control write while a transaction is active leaves `hs_code` unchanged and still lets the transaction complete. The new value governs the next token.
- R12: When a CPU write and a hardware update of force NAK, short enable or the toggle fall on the same cycle, the hardware value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Control byte write strobe |
| cpu_wdata | input | 8 | Control byte write data |
| cpu_rdata | output | 8 | Status byte read data |
| max_pkt | input | CNT_W | Endpoint max packet size in bytes |
| tok_in | input | 1 | IN token strobe |
| tok_out | input | 1 | OUT token strobe |
| done_ok | input | 1 | Transaction completed normally |
| done_err | input | 1 | Transaction ended without success |
| rx_count | input | CNT_W | Bytes received in the OUT packet, valid with `done_ok` |
| fifo_count | input | CNT_W | Bytes waiting in the FIFO |
| fifo_free | input | CNT_W | Free bytes in the FIFO |
| hs_valid | output | 1 | One-cycle pulse: a new handshake decision |
| hs_code | output | 2 | 00 data/ACK, 01 NAK, 10 STALL; held until the next token |
| hs_toggle | output | 1 | Data toggle for this transaction |
| tx_len | output | CNT_W | Bytes to send for an IN data answer |

## Verification
The bench checks the points where an IN packet becomes short. These are one byte below the max size with and without short enable, and an empty FIFO, which must give a zero-length packet rather than NAK. A design that compared the wrong way would NAK full packets or send partial ones. It also fires completion strobes after NAK answers and after failed transactions: a design that flipped the toggle there would lose data sync with the host. It writes STALL in the middle of an accepted transaction, which a design without the token-time latch would show at once. It collides a CPU write with a hardware update, where a design giving the CPU priority would drop an auto-NAK.

// File: rtl/ep_handshake_ctrl.sv
module ep_handshake_ctrl #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             tok_in,
  input  logic             tok_out,
  input  logic             done_ok,
  input  logic             done_err,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] fifo_free,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             hs_toggle,
  output logic [CNT_W-1:0] tx_len
);
  localparam logic [1:0] HS_DATA  = 2'b00;
  localparam logic [1:0] HS_NAK   = 2'b01;
  localparam logic [1:0] HS_STALL = 2'b10;

  logic auto_nak, short_en, short_nak_off, toggle, force_nak, force_stall;
  logic active, act_in, act_short;

  logic             tok_any;
  logic             in_short;
  logic [1:0]       next_code;
  logic [CNT_W-1:0] next_len;
  logic             finish_ok;

  assign tok_any   = tok_in | tok_out;
  assign in_short  = fifo_count < max_pkt;
  assign finish_ok = done_ok & active;
  assign cpu_rdata = {auto_nak, short_en, short_nak_off, toggle, 2'b00, force_nak, force_stall};

  always_comb begin
    next_code = HS_DATA;
    next_len  = '0;
    if (force_stall)
      next_code = HS_STALL;
    else if (force_nak)
      next_code = HS_NAK;
    else if (tok_in) begin
      if (in_short && !short_en)
        next_code = HS_NAK;
      else
        next_len = in_short ? fifo_count : max_pkt;
    end else if (fifo_free < max_pkt)
      next_code = HS_NAK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      auto_nak      <= 1'b0;
      short_en      <= 1'b0;
      short_nak_off <= 1'b0;
      toggle        <= 1'b0;
      force_nak     <= 1'b0;
      force_stall   <= 1'b0;
      active        <= 1'b0;
      act_in        <= 1'b0;
      act_short     <= 1'b0;
      hs_valid      <= 1'b0;
      hs_code       <= HS_DATA;
      hs_toggle     <= 1'b0;
      tx_len        <= '0;
    end else begin
      if (cpu_wr) begin
        auto_nak      <= cpu_wdata[7];
        short_en      <= cpu_wdata[6];
        short_nak_off <= cpu_wdata[5];
        force_nak     <= cpu_wdata[1];
        force_stall   <= cpu_wdata[0];
        if (cpu_wdata[2])
          toggle <= 1'b0;
        else if (cpu_wdata[3])
          toggle <= 1'b1;
      end
      if (done_ok | done_err)
        active <= 1'b0;
      if (finish_ok) begin
        toggle <= ~toggle;
        if (auto_nak)
          force_nak <= 1'b1;
        else if (!act_in && !short_nak_off && rx_count < max_pkt)
          force_nak <= 1'b1;
        if (act_in && act_short)
          short_en <= 1'b0;
      end
      hs_valid <= tok_any;
      if (tok_any) begin
        hs_code   <= next_code;
        tx_len    <= next_len;
        hs_toggle <= toggle;
        active    <= next_code == HS_DATA;
        act_in    <= tok_in;
        act_short <= tok_in & in_short;
      end
    end
  end

  assert_stall_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_any && force_stall |=> hs_valid && hs_code == HS_STALL);

  assert_nak_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tok_any && force_nak && !force_stall |=> hs_valid && hs_code == HS_NAK);

  assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_ok && !(cpu_wr && (cpu_wdata[3] || cpu_wdata[2])) |=> $stable(toggle));

  assert_auto_nak_R8: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ok && auto_nak |=> force_nak);

  assert_short_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ok && act_in && act_short |=> !short_en);

  assert_code_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_any |=> $stable(hs_code) && !hs_valid);

  assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> hs_code != 2'b11 && (hs_code == HS_DATA || tx_len == '0));
endmodule

// File: tb/ep_handshake_ctrl_tb.sv
`timescale 1ns/1ps
module ep_handshake_ctrl_tb;
  localparam int CNT_W = 11;
  localparam int NVEC  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [CNT_W-1:0] max_pkt = 11'd64;
  logic tok_in = 1'b0, tok_out = 1'b0, done_ok = 1'b0, done_err = 1'b0;
  logic [CNT_W-1:0] rx_count = '0, fifo_count = '0, fifo_free = '0;
  logic hs_valid, hs_toggle;
  logic [1:0] hs_code;
  logic [CNT_W-1:0] tx_len;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ep_handshake_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .max_pkt(max_pkt), .tok_in(tok_in), .tok_out(tok_out), .done_ok(done_ok), .done_err(done_err),
    .rx_count(rx_count), .fifo_count(fifo_count), .fifo_free(fifo_free),
    .hs_valid(hs_valid), .hs_code(hs_code), .hs_toggle(hs_toggle), .tx_len(tx_len));

  // ctrl[43:36] dir_in[35] count[34:24] free[23:13] code[12:11] len[10:0]
  localparam logic [43:0] VEC [NVEC] = '{
    {8'h00, 1'b1, 11'd64,  11'd0,   2'd0, 11'd64},
    {8'h00, 1'b1, 11'd63,  11'd0,   2'd1, 11'd0},
    {8'h40, 1'b1, 11'd10,  11'd0,   2'd0, 11'd10},
    {8'h40, 1'b1, 11'd0,   11'd0,   2'd0, 11'd0},
    {8'h02, 1'b1, 11'd64,  11'd0,   2'd1, 11'd0},
    {8'h03, 1'b1, 11'd64,  11'd0,   2'd2, 11'd0},
    {8'h00, 1'b0, 11'd0,   11'd64,  2'd0, 11'd0},
    {8'h00, 1'b0, 11'd0,   11'd63,  2'd1, 11'd0},
    {8'h02, 1'b0, 11'd0,   11'd100, 2'd1, 11'd0},
    {8'h01, 1'b0, 11'd0,   11'd0,   2'd2, 11'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic token(input bit is_in);
    tok_in = is_in; tok_out = !is_in;
    @(negedge clk);
    tok_in = 1'b0; tok_out = 1'b0;
  endtask

  task automatic finish_tx(input bit ok, input int rx);
    done_ok = ok; done_err = !ok; rx_count = CNT_W'(rx);
    @(negedge clk);
    done_ok = 1'b0; done_err = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rdata", cpu_rdata, 8'h00);
    chk("R1 reset hs_valid", hs_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][43:36]);
      fifo_count = VEC[i][34:24];
      fifo_free  = VEC[i][23:13];
      token(VEC[i][35]);
      chk($sformatf("R3/R4/R5/R6 vec%0d valid", i), hs_valid, 1);
      chk($sformatf("R3/R4/R5/R6 vec%0d code", i), hs_code, VEC[i][12:11]);
      chk($sformatf("R5 vec%0d len", i), tx_len, VEC[i][10:0]);
      @(negedge clk);
      chk("R11 valid is a pulse", hs_valid, 0);
    end

    // R1 layout, R2 toggle control
    wr(8'hE3);
    chk("R1 layout", cpu_rdata, 8'hE3);
    wr(8'h08);
    chk("R2 toggle set", cpu_rdata, 8'h10);
    wr(8'h00);
    chk("R2 zero write keeps toggle", cpu_rdata, 8'h10);
    wr(8'h0C);
    chk("R2 clear wins", cpu_rdata, 8'h00);
    wr(8'h08);
    wr(8'h04);
    chk("R2 toggle clear", cpu_rdata, 8'h00);

    // R7 toggle rules
    fifo_count = 11'd64; fifo_free = 11'd64;
    token(1'b1);
    chk("R7 hs_toggle at token", hs_toggle, 0);
    finish_tx(1'b1, 0);
    chk("R7 flip on ok", cpu_rdata[4], 1);
    token(1'b1);
    chk("R7 hs_toggle follows", hs_toggle, 1);
    finish_tx(1'b0, 0);
    chk("R7 no flip on err", cpu_rdata[4], 1);
    wr(8'h02);
    token(1'b1);
    finish_tx(1'b1, 0);
    chk("R7 no flip after NAK", cpu_rdata[4], 1);
    wr(8'h01);
    token(1'b0);
    finish_tx(1'b1, 0);
    chk("R7 no flip after STALL", cpu_rdata[4], 1);

    // R8 auto NAK
    wr(8'h84);
    token(1'b0);
    finish_tx(1'b1, 64);
    chk("R8 auto NAK", cpu_rdata, 8'h92);

    // R9 short OUT
    wr(8'h04);
    token(1'b0);
    finish_tx(1'b1, 10);
    chk("R9 short OUT sets NAK", cpu_rdata, 8'h12);
    wr(8'h24);
    token(1'b0);
    finish_tx(1'b1, 10);
    chk("R9 disabled short NAK", cpu_rdata, 8'h30);
    wr(8'h04);
    token(1'b0);
    finish_tx(1'b1, 64);
    chk("R9 full OUT no NAK", cpu_rdata, 8'h10);

    // R10 short enable self clear
    wr(8'h44);
    fifo_count = 11'd10;
    token(1'b1);
    chk("R10 short sent", tx_len, 10);
    finish_tx(1'b1, 0);
    chk("R10 short enable cleared", cpu_rdata, 8'h10);
    wr(8'h44);
    fifo_count = 11'd64;
    token(1'b1);
    finish_tx(1'b1, 0);
    chk("R10 full keeps enable", cpu_rdata, 8'h50);

    // R11 mid-transaction write
    wr(8'h04);
    token(1'b0);
    chk("R11 accepted", hs_code, 0);
    wr(8'h01);
    chk("R11 code held", hs_code, 0);
    finish_tx(1'b1, 64);
    chk("R11 still completes", cpu_rdata, 8'h11);
    token(1'b0);
    chk("R11 next token STALL", hs_code, 2);

    // R12 hardware wins
    wr(8'h84);
    token(1'b0);
    cpu_wr = 1'b1; cpu_wdata = 8'h80;
    done_ok = 1'b1; rx_count = 11'd64;
    @(negedge clk);
    cpu_wr = 1'b0; done_ok = 1'b0;
    chk("R12 hardware NAK wins", cpu_rdata[1], 1);
    wr(8'h44);
    fifo_count = 11'd5;
    token(1'b1);
    cpu_wr = 1'b1; cpu_wdata = 8'h40;
    done_ok = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; done_ok = 1'b0;
    chk("R12 hardware clear wins", cpu_rdata, 8'h10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule